// File: doc/BRIEF.md
# Programmable Delay Line Buffer

This block delays a 10-bit sample stream by a latency that is chosen at run time, anywhere from 2 to 2049 clocks. The path is an input register, then a 2048-word delay memory whose read address trails the write address by a programmed distance, then an output register. The value held in the length register is therefore the wanted latency minus 2. A value of 0 gives a latency of 2. Data moves only on clocks where the clock enable is high, so a low enable freezes the whole path in place.

A mode input chooses where the input register takes its data from. In delay mode it takes the external input. In recirculation mode it takes the block's own output, so a loaded pattern circulates with a period of the programmed length plus 2. A new length is loaded on an enabled clock while the active-low load strobe is low. It takes effect at once, with no flushing. The active clock edge is fixed by a parameter. An active-low output enable forces the output bus to zero when it is high.

Top module: `prog_delay_line`

## Requirements
- R1: A synchronous reset (rst high) clears the pipeline registers, the write pointer and the length register. With oe_n low, dout reads 0 while reset is held, and the latency after reset is 2.
- R2: In delay mode (recirc = 0), a sample on din at enabled clock t appears on dout just after enabled clock t+L-1, where L = len+2 and len is the length register value (0 to 2047). The memory pointer wraps modulo 2048.
- R3: On an enabled clock with len_ld_n = 0, len_in is captured into the length register. When len_ld_n = 1, len_in has no effect on the length.
- R4: In recirculation mode (recirc = 1), the input register takes the current output instead of din, so the stream repeats with period len+2 and din is ignored.
- R5: When ce = 0, the pipeline registers, the pointer, the memory and the length register all hold their values.
- R6: When oe_n = 1, dout is all zeros. The internal state is not affected.
- R7: A length change while data streams takes effect from the next clock. The output then equals the input delayed by the new length plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by the FALL_EDGE parameter |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes all state |
| recirc | input | 1 | 0 = delay mode, 1 = recirculation mode |
| len_ld_n | input | 1 | Active-low length load strobe |
| len_in | input | 11 | Length value, wanted latency minus 2 |
| oe_n | input | 1 | Active-low output enable |
| din | input | 10 | Sample input |
| dout | output | 10 | Sample output, zero when oe_n is high |

## Verification
The bench goes after the two ends of the length range. A length of 0 needs the memory to be bypassed, so a design that read the RAM there would return stale data one lap old. A length of 2047 forces the pointer to wrap, and an off-by-one in the read address would shift every sample by a clock. The bench also toggles the enable at random, and a design that let the pointer or the memory move while frozen would slip the stream. It changes the length in mid-stream, where a design that flushed or delayed the update would mismatch. It drives random data while in recirculation mode, so a design that leaked din into the loop would corrupt the repeating pattern. It also feeds junk to len_in while the load strobe is high, which a design that ignored the strobe would pick up as a new length.

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int W = 10,
  parameter int LW = 11,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          recirc,
  input  logic          len_ld_n,
  input  logic [LW-1:0] len_in,
  input  logic          oe_n,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int DEPTH = 2 ** LW;

  logic          aclk;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  in_q, out_q, rd;
  logic [LW-1:0] len_q, wptr;

  generate
    if (FALL_EDGE) begin : g_fall
      assign aclk = ~clk;
    end else begin : g_rise
      assign aclk = clk;
    end
  endgenerate

  assign rd   = (len_q == '0) ? in_q : mem[wptr - len_q];
  assign dout = oe_n ? '0 : out_q;

  always_ff @(posedge aclk) begin
    if (ce) mem[wptr] <= in_q;
  end

  always_ff @(posedge aclk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
      len_q <= '0;
      wptr  <= '0;
    end else if (ce) begin
      in_q  <= recirc ? out_q : din;
      out_q <= rd;
      wptr  <= wptr + 1'b1;
      if (!len_ld_n) len_q <= len_in;
    end
  end
endmodule

// File: rtl/prog_delay_line_chk.sv
module prog_delay_line_chk #(
  parameter int W = 10,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic          recirc,
  input logic          len_ld_n,
  input logic [LW-1:0] len_in,
  input logic [W-1:0]  din,
  input logic [W-1:0]  in_q,
  input logic [W-1:0]  out_q,
  input logic [LW-1:0] len_q,
  input logic [LW-1:0] wptr
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  short_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && ce && $past(ce) && !$past(recirc) && len_q == '0) |=> out_q == $past(din, 2));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> wptr == LW'($past(wptr) + 1'b1));

  // R3
  len_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !len_ld_n) |=> len_q == $past(len_in));

  // R3
  len_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && len_ld_n) |=> $stable(len_q));

  // R4
  loop_back_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && recirc) |=> in_q == $past(out_q));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(out_q) && $stable(in_q) && $stable(wptr) && $stable(len_q)));
endmodule

bind prog_delay_line prog_delay_line_chk #(.W(W), .LW(LW)) u_chk (
  .clk(aclk), .rst(rst), .ce(ce), .recirc(recirc), .len_ld_n(len_ld_n),
  .len_in(len_in), .din(din), .in_q(in_q), .out_q(out_q), .len_q(len_q), .wptr(wptr)
);

// File: tb/tb_prog_delay_line.sv
`timescale 1ns/1ps
module tb_prog_delay_line;
  logic clk = 1'b0;
  logic rst, ce, recirc, len_ld_n, oe_n;
  logic [10:0] len_in;
  logic [9:0] din, dout;

  always #2.5 clk = ~clk;

  prog_delay_line dut (
    .clk(clk), .rst(rst), .ce(ce), .recirc(recirc), .len_ld_n(len_ld_n),
    .len_in(len_in), .oe_n(oe_n), .din(din), .dout(dout)
  );

  typedef struct {
    logic [9:0] v;
    bit         chk;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [9:0] sv [4096];
  bit         sk [4096];
  int         k, len_m;
  logic [9:0] cur;
  bit         curk;

  task automatic step(input bit r, input bit c, input bit rc, input bit ldn,
                      input logic [10:0] lv, input logic [9:0] d, input bit oen,
                      input string tag);
    item_t it;
    int j;
    logic [9:0] e;
    bit ek;
    @(negedge clk);
    rst = r; ce = c; recirc = rc; len_ld_n = ldn; len_in = lv; din = d; oe_n = oen;
    if (r) begin
      k = 0; sv[0] = '0; sk[0] = 1; cur = '0; curk = 1; len_m = 0;
    end else if (c) begin
      k++;
      j = k - 1 - len_m;
      if (j >= 0) begin e = sv[j & 4095]; ek = sk[j & 4095]; end
      else begin e = '0; ek = 0; end
      sv[k & 4095] = rc ? cur : d;
      sk[k & 4095] = rc ? curk : 1'b1;
      cur = e; curk = ek;
      if (!ldn) len_m = int'(lv);
    end
    it.v = oen ? '0 : cur;
    it.chk = oen ? 1'b1 : curk;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input bit rc, input int cep, input int oep, input string tag);
    for (int i = 0; i < n; i++)
      step(0, ($urandom % 100) < cep, rc, 1'b1, 11'($urandom), 10'($urandom),
           ($urandom % 100) < oep, tag);
  endtask

  task automatic load(input int l, input string tag);
    step(0, 1'b1, 1'b0, 1'b0, 11'(l), 10'($urandom), 1'b0, tag);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk) begin
          total++;
          if (dout !== it.v) begin
            bad++;
            $display("FAIL %s: dout=%0h expected=%0h", it.tag, dout, it.v);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: ran out of cycles");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; ce = 1; recirc = 0; len_ld_n = 1; len_in = '0; din = '0; oe_n = 0;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 11'h7ff, 10'($urandom), 0, "R1");
    run(12, 0, 100, 0, "R1");
    load(5, "R3");
    run(30, 0, 100, 0, "R3");
    load(1, "R2");
    run(20, 0, 100, 0, "R2");
    load(0, "R2");
    run(20, 0, 100, 0, "R2");
    load(2047, "R2");
    run(2080, 0, 100, 0, "R2");
    load(13, "R7");
    run(40, 0, 100, 0, "R7");
    load(3, "R7");
    run(25, 0, 100, 0, "R7");
    load(40, "R7");
    run(90, 0, 100, 0, "R7");
    load(7, "R5");
    run(200, 0, 50, 0, "R5");
    run(100, 0, 100, 50, "R6");
    run(20, 0, 100, 0, "R6");
    load(6, "R4");
    run(12, 0, 100, 0, "R4");
    run(60, 1, 100, 0, "R4");
    run(60, 1, 60, 20, "R4");
    run(10, 0, 100, 0, "R4");
    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule